// File: doc/BRIEF.md
# Memory Chip-Select Decoder

This block sits between a processor's 20-bit physical address bus and a group of memory banks. It turns each memory cycle into a single active-low chip select for the bank that owns the address. It also passes on the in-bank offset that every bank sees. The address and the read and write strobes are captured on a clock edge, and the selects are then decoded from that held copy. The outputs therefore stay steady for the whole cycle.

The address is split into three fields. The low `OFS_W` bits form the offset inside a bank. The next `SEL_W` bits form the decode slot. Any bits above the slot are ignored. When the slot reaches the top address bit, decoding is full and every bank appears exactly once in the map. When `SEL_W` is smaller, decoding is partial: the ignored bits make each bank answer at several physical addresses. Banks fill consecutive slots starting at `FIRST_SLOT`. A slot with no bank is a hole, and a memory cycle that lands in a hole raises the unmapped flag instead of a select.

Typical settings are two 512 KB banks (`OFS_W`=19, `SEL_W`=1), four 256 KB banks (`OFS_W`=18, `SEL_W`=2) and up to 128 banks of 8 KB (`OFS_W`=13, `SEL_W`=7). The default is a partial-decode map: three 128 KB banks in slots 1 to 3, a hole in slot 0, and A19 ignored.

Top module: `memsel_decoder`

## Requirements
- R1: While `rst_n` is low, all chip selects are high, `unmapped_o` is low and `offset_o` is zero, whatever the inputs do.
- R2: The address and strobes are sampled on the rising clock edge. Outputs change only after that edge and reflect the values captured there.
- R3: When both `mem_rd_n_i` and `mem_wr_n_i` are high (idle bus), every chip select is high and `unmapped_o` is low, for any address.
- R4: During a memory cycle, bank k (bit k of `cs_n_o`) is driven low when the slot field `addr_i[OFS_W+SEL_W-1:OFS_W]` equals `FIRST_SLOT`+k.
- R5: `offset_o` equals `addr_i[OFS_W-1:0]` as captured on the last edge.
- R6: Address bits above `OFS_W+SEL_W` have no effect on selection or offset. With the defaults, 0x20023 and 0xA0023 both select bank 0 at offset 0x00023.
- R7: A memory cycle whose slot holds no bank raises `unmapped_o` and drives no select. With the defaults, addresses with A18:A17 = 00 are a hole.
- R8: At most one chip select is low at any time. During a memory cycle, exactly one of "one select low" and "`unmapped_o` high" holds.
- R9: A cycle is a memory cycle when either strobe is low; when both are low it is still a single cycle with one decode.
- R10: With full decoding of a single 512 KB bank placed high (`OFS_W`=19, `SEL_W`=1, `NUM_BANKS`=1, `FIRST_SLOT`=1), the bank is selected only when A19=1, and 0x00000–0x7FFFF is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Physical address of the current bus cycle |
| mem_rd_n_i | input | 1 | Active-low memory read strobe |
| mem_wr_n_i | input | 1 | Active-low memory write strobe |
| cs_n_o | output | NUM_BANKS | Active-low chip select, one bit per bank |
| offset_o | output | OFS_W | Offset inside the selected bank |
| unmapped_o | output | 1 | Memory cycle hit a slot with no bank |

## Verification
The two functions that can land in the same cycle are bank selection and the hole flag, together with a read and a write strobe asserted at once. Random strobe pairs include the case where both strobes are low, and random addresses cover mapped slots, holes and aliased upper bits. Two instances are checked side by side: the partial-decode default and a fully decoded single high bank. On every cycle, the bench judges that there is either one select or the flag and never both, that the right bank is chosen, and that the offset follows. Its expected values come from a slot model of its own.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    // Kind of bus cycle held in the capture register; bit 0 = read, bit 1 = write
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10,
        CYC_BOTH  = 2'b11
    } cyc_kind_e;

    function automatic logic cyc_is_mem(input cyc_kind_e kind);
        return kind != CYC_IDLE;
    endfunction

endpackage

// File: rtl/memsel_latch.sv
module memsel_latch
    import memsel_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output cyc_kind_e         kind_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        cyc_kind_e         kind;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.addr = addr_i;
        cap_d.kind = cyc_kind_e'({~wr_n_i, ~rd_n_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_o = cap_q.addr;
    assign kind_o = cap_q.kind;

endmodule

// File: rtl/memsel_split.sv
module memsel_split #(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 17,
    parameter int SEL_W  = 2,
    localparam int SEL_WE = (SEL_W > 0) ? SEL_W : 1,
    localparam int TOP_B  = OFS_W + SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OFS_W-1:0]  offset_o,
    output logic [SEL_WE-1:0] slot_o
);

    assign offset_o = addr_i[OFS_W-1:0];

    generate
        if (SEL_W > 0) begin : g_slot
            assign slot_o = addr_i[TOP_B-1:OFS_W];
        end else begin : g_noslot
            assign slot_o = '0;
        end

        if (TOP_B < ADDR_W) begin : g_alias
            // Bits above the slot take no part in decoding; they alias
            logic unused_hi;
            assign unused_hi = ^addr_i[ADDR_W-1:TOP_B];
        end
    endgenerate

endmodule

// File: rtl/memsel_bank_dec.sv
module memsel_bank_dec #(
    parameter int SEL_WE     = 2,
    parameter int NUM_BANKS  = 3,
    parameter int FIRST_SLOT = 1
) (
    input  logic [SEL_WE-1:0]    slot_i,
    input  logic                 active_i,
    output logic [NUM_BANKS-1:0] cs_n_o,
    output logic                 hit_o
);

    generate
        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
            assign cs_n_o[k] = !(active_i && (slot_i == SEL_WE'(FIRST_SLOT + k)));
        end
    endgenerate

    assign hit_o = ~&cs_n_o;

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int OFS_W      = 17,
    parameter int SEL_W      = 2,
    parameter int NUM_BANKS  = 3,
    parameter int FIRST_SLOT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 mem_rd_n_i,
    input  logic                 mem_wr_n_i,
    output logic [NUM_BANKS-1:0] cs_n_o,
    output logic [OFS_W-1:0]     offset_o,
    output logic                 unmapped_o
);

    localparam int SEL_WE = (SEL_W > 0) ? SEL_W : 1;

    logic [ADDR_W-1:0] addr_q;
    cyc_kind_e         kind_q;
    logic [SEL_WE-1:0] slot;
    logic              mem_cyc;
    logic              hit;

    memsel_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .rd_n_i (mem_rd_n_i),
        .wr_n_i (mem_wr_n_i),
        .addr_o (addr_q),
        .kind_o (kind_q)
    );

    memsel_split #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .SEL_W  (SEL_W)
    ) u_split (
        .addr_i   (addr_q),
        .offset_o (offset_o),
        .slot_o   (slot)
    );

    assign mem_cyc = cyc_is_mem(kind_q);

    memsel_bank_dec #(
        .SEL_WE     (SEL_WE),
        .NUM_BANKS  (NUM_BANKS),
        .FIRST_SLOT (FIRST_SLOT)
    ) u_dec (
        .slot_i   (slot),
        .active_i (mem_cyc),
        .cs_n_o   (cs_n_o),
        .hit_o    (hit)
    );

    assign unmapped_o = mem_cyc && !hit;

endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
    parameter int ADDR_W     = 20,
    parameter int OFS_W      = 17,
    parameter int SEL_W      = 2,
    parameter int NUM_BANKS  = 3,
    parameter int FIRST_SLOT = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 mem_rd_n_i,
    input logic                 mem_wr_n_i,
    input logic [NUM_BANKS-1:0] cs_n_o,
    input logic [OFS_W-1:0]     offset_o,
    input logic                 unmapped_o
);

    logic cyc_in;
    int   slot_in;
    logic in_map;

    assign cyc_in = !mem_rd_n_i || !mem_wr_n_i;

    generate
        if (SEL_W > 0) begin : g_s
            assign slot_in = int'(addr_i[OFS_W+SEL_W-1:OFS_W]);
        end else begin : g_ns
            assign slot_in = 0;
        end
    endgenerate

    assign in_map = (slot_in >= FIRST_SLOT) && (slot_in < FIRST_SLOT + NUM_BANKS);

    // R1: reset keeps the bus quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> ((&cs_n_o) && !unmapped_o));

    // R3: idle bus selects nothing and flags nothing
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n_i && mem_wr_n_i) |=> ((&cs_n_o) && !unmapped_o));

    // R4 / R9: a mapped memory cycle gives exactly one select
    p_mapped_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_in && in_map) |=> (!unmapped_o && ($countones(~cs_n_o) == 1)));

    // R5 / R2: offset follows the address captured one edge earlier
    p_offset_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_in |=> (offset_o == $past(addr_i[OFS_W-1:0])));

    // R7: a hole raises the flag with no select
    p_hole_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_in && !in_map) |=> (unmapped_o && (&cs_n_o)));

    // R8: never two selects at once
    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R8: flag and select never coexist
    p_flag_vs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_o |-> (&cs_n_o));

endmodule

bind memsel_decoder memsel_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .SEL_W      (SEL_W),
    .NUM_BANKS  (NUM_BANKS),
    .FIRST_SLOT (FIRST_SLOT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .mem_rd_n_i (mem_rd_n_i),
    .mem_wr_n_i (mem_wr_n_i),
    .cs_n_o     (cs_n_o),
    .offset_o   (offset_o),
    .unmapped_o (unmapped_o)
);

// File: tb/memsel_decoder_test.sv
module memsel_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] addr;
    logic        rd_n;
    logic        wr_n;

    logic [2:0]  cs_n;
    logic [16:0] offs;
    logic        unm;
    logic [0:0]  csf;
    logic [18:0] offf;
    logic        unmf;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    // Default map: 128 KB banks, slot A18:A17, banks in slots 1..3, A19 ignored
    memsel_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .mem_rd_n_i(rd_n), .mem_wr_n_i(wr_n),
        .cs_n_o(cs_n), .offset_o(offs), .unmapped_o(unm)
    );

    // Full decode, single 512 KB bank placed high
    memsel_decoder #(
        .ADDR_W(20), .OFS_W(19), .SEL_W(1), .NUM_BANKS(1), .FIRST_SLOT(1)
    ) uut_full (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .mem_rd_n_i(rd_n), .mem_wr_n_i(wr_n),
        .cs_n_o(csf), .offset_o(offf), .unmapped_o(unmf)
    );

    function automatic logic [7:0] exp_sel(input logic [19:0] a, input bit act,
                                           input int ofs, input int selw,
                                           input int nb, input int first);
        int slot;
        logic [7:0] r;
        slot = (selw == 0) ? 0 : int'((a >> ofs) & ((20'd1 << selw) - 20'd1));
        r = '1;
        for (int k = 0; k < nb; k++)
            if (act && (slot == first + k)) r[k] = 1'b0;
        return r;
    endfunction

    function automatic logic exp_hole(input logic [19:0] a, input bit act,
                                      input int ofs, input int selw,
                                      input int nb, input int first);
        int slot;
        slot = (selw == 0) ? 0 : int'((a >> ofs) & ((20'd1 << selw) - 20'd1));
        return act && ((slot < first) || (slot >= first + nb));
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Drive at the current falling edge, check at the next falling edge
    task automatic apply(input logic [19:0] a, input logic rd, input logic wr,
                         input string tag);
        bit act;
        logic [7:0] e;
        logic [7:0] ef;
        addr = a;
        rd_n = rd;
        wr_n = wr;
        act  = !(rd && wr);
        @(negedge clk);
        e  = exp_sel(a, act, 17, 2, 3, 1);
        ef = exp_sel(a, act, 19, 1, 1, 1);
        chk(tag, "cs_n R4", {29'd0, cs_n}, {29'd0, e[2:0]});
        chk(tag, "unmapped R7", {31'd0, unm}, {31'd0, exp_hole(a, act, 17, 2, 3, 1)});
        chk(tag, "offset R5", {15'd0, offs}, {15'd0, a[16:0]});
        chk(tag, "one-of R8", {31'd0, (($countones(~cs_n) + int'(unm)) == (act ? 1 : 0))}, 32'd1);
        chk(tag, "full cs_n R10", {31'd0, csf}, {31'd0, ef[0]});
        chk(tag, "full unmapped R10", {31'd0, unmf}, {31'd0, exp_hole(a, act, 19, 1, 1, 1)});
        chk(tag, "full offset R10", {13'd0, offf}, {13'd0, a[18:0]});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        addr  = 20'h0;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset", "cs_n", {29'd0, cs_n}, 32'h7);
        chk("R1 reset", "unmapped", {31'd0, unm}, 32'd0);
        chk("R1 reset", "offset", {15'd0, offs}, 32'd0);
        // Inputs active during reset must not reach the outputs
        addr = 20'h2ABCD;
        rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 busy during reset", "cs_n", {29'd0, cs_n}, 32'h7);
        chk("R1 busy during reset", "full cs_n", {31'd0, csf}, 32'd1);
        chk("R1 busy during reset", "offset", {15'd0, offs}, 32'd0);
        rd_n  = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        apply(20'h05000, 1'b1, 1'b1, "R3 idle on hole");
        apply(20'h20023, 1'b0, 1'b1, "R4 read bank0");
        apply(20'hA0023, 1'b0, 1'b1, "R6 alias of 20023");
        chk("R6 alias", "bank0 low", {31'd0, cs_n[0]}, 32'd0);
        apply(20'h05000, 1'b1, 1'b0, "R7 write into hole");
        apply(20'h7FFFF, 1'b0, 1'b0, "R9 both strobes");
        apply(20'h40000, 1'b1, 1'b0, "R4 bank1 base");
        apply(20'h80000, 1'b0, 1'b1, "R10 base of high half");
        apply(20'h7FFFF, 1'b0, 1'b1, "R10 top of low half");
        apply(20'hFFFFF, 1'b1, 1'b0, "R6 R10 top address");
        apply(20'hE0001, 1'b1, 1'b1, "R3 idle mapped");

        // R2: new inputs at a falling edge do not show before the rising edge
        apply(20'h21111, 1'b0, 1'b1, "R2 setup");
        addr = 20'h62222;
        rd_n = 1'b1;
        wr_n = 1'b0;
        #5;
        chk("R2 before edge", "offset", {15'd0, offs}, 32'h01111);
        chk("R2 before edge", "cs_n", {29'd0, cs_n}, 32'h6);
        @(negedge clk);
        chk("R2 after edge", "offset", {15'd0, offs}, 32'h02222);
        chk("R2 after edge", "cs_n", {29'd0, cs_n}, 32'h3);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] s;
            r = $urandom;
            s = $urandom;
            apply(r[19:0], s[0], s[1], "R4 R7 R8 R9 random");
        end

        summary();
        $finish;
    end

endmodule